// File: doc/BRIEF.md
# Base-Register Cache Way Memoization Unit

This unit sits beside the address-generation stage of a load/store pipeline. For every architectural register it keeps a small record: a valid bit, the cache line address, the level-one data cache way and the data TLB way last used by a memory access that took that register as its base. When a new load or store has computed its address, the unit reads the base register's record in the same cycle. If the record is valid and the address lies in the same line, the unit reports the stored ways. The pipeline then skips both the L1 tag read and the TLB lookup. A load enables only one data way.

The scheme is non-speculative. A record only exists while the line and the translation it names are known to still be resident, so a match never needs a replay. Several events remove records:

- an L1 eviction or fill names a set and way, and every record pointing at that set and way is dropped;
- a TLB replacement names a TLB way, and every record pointing at that way is dropped;
- a non-memory instruction writes a register, and that register's record is dropped.

A miss is followed by the full lookup. When that lookup completes, its ways are written back into the record. A post-increment memory access needs no action, because the match is always made on the freshly computed address.

Top module: `way_memo_unit`

## Requirements
- R1: After reset every record is invalid, so every lookup misses (lk_hit_o = 0).
- R2: A lookup hits when the base register's record is valid and bits [31:6] of lk_addr_i equal the stored line address, whatever the low 6 offset bits are. On a hit, lk_l1_way_o and lk_tlb_way_o carry the stored way indices (binary encoded).
- R3: A lookup misses when the record is invalid or the line address differs, including an address in the same set with a different tag. A cycle with lk_valid_i = 0 never hits.
- R4: On a hit, tag_en_o and tlb_en_o are both 0. On a valid lookup that misses, both are 1. With no lookup, both are 0.
- R5: data_way_en_o has bit i for L1 way i. It equals 1 << way on a load hit, all ones on a load miss, and zero for stores or when there is no lookup.
- R6: A fill (fill_valid_i) writes the record of fill_reg_i with the line of fill_addr_i and both ways. Lookups see it from the next cycle.
- R7: A non-memory register write (rwr_valid_i) invalidates only the record of rwr_reg_i, from the next cycle.
- R8: An L1 eviction (l1_inv_valid_i) invalidates every record whose set index (line address bits [5:0], i.e. address bits [11:6]) equals l1_inv_set_i and whose L1 way equals l1_inv_way_i. All other records are kept.
- R9: A TLB replacement (tlb_inv_valid_i) invalidates every record whose TLB way equals tlb_inv_way_i.
- R10: A fill is discarded, leaving the record invalid, when in the same cycle the target register is written by a non-memory instruction, or an L1 eviction names the fill's set and way, or a TLB replacement names the fill's TLB way.
- R11: A lookup is answered from the table as it stood at the start of the cycle. A fill or invalidation in the same cycle affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Memory access with computed address this cycle |
| lk_is_load_i | input | 1 | Access is a load (0 = store) |
| lk_base_i | input | 5 | Base register index |
| lk_addr_i | input | 32 | Computed effective address |
| lk_hit_o | output | 1 | Address lies in the memoized line |
| lk_l1_way_o | output | 2 | Memoized L1 way on hit |
| lk_tlb_way_o | output | 2 | Memoized TLB way on hit |
| tag_en_o | output | 1 | L1 tag array access enable |
| tlb_en_o | output | 1 | TLB lookup enable |
| data_way_en_o | output | 4 | Per-way L1 data array enable for loads |
| fill_valid_i | input | 1 | Completed full lookup to record |
| fill_reg_i | input | 5 | Register whose record is written |
| fill_addr_i | input | 32 | Address of the completed access |
| fill_l1_way_i | input | 2 | L1 way found by the full lookup |
| fill_tlb_way_i | input | 2 | TLB way found by the full lookup |
| rwr_valid_i | input | 1 | Non-memory instruction writes a register |
| rwr_reg_i | input | 5 | Register written |
| l1_inv_valid_i | input | 1 | L1 eviction or fill into a set/way |
| l1_inv_set_i | input | 6 | Set index of that event |
| l1_inv_way_i | input | 2 | Way of that event |
| tlb_inv_valid_i | input | 1 | TLB entry replaced |
| tlb_inv_way_i | input | 2 | Replaced TLB way |

## Verification
The checker holds the enable contract on every cycle. A hit never opens the tag array or the TLB, a load hit opens exactly the reported data way, and a hit never appears without a lookup. It also checks that no lookup in the cycle after a register write, L1 eviction or TLB replacement can hit on a record that event should have removed. Whether a hit happens when it should — the fill being written with the right line and ways, the offset-insensitive compare, the survival of records an invalidation must spare, and the same-cycle ordering of fills against invalidations — depends on history. Only the bench's reference model, compared on every clock across directed scenarios and a long random stream, can show these.

// File: rtl/wm_pkg.sv
package wm_pkg;
  parameter int NUM_REGS   = 32;
  parameter int ADDR_W     = 32;
  parameter int LINE_BYTES = 64;
  parameter int L1_SETS    = 64;
  parameter int L1_WAYS    = 4;
  parameter int TLB_WAYS   = 4;

  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int LINE_W    = ADDR_W - OFF_W;
  localparam int SET_W     = $clog2(L1_SETS);
  localparam int L1_WAY_W  = $clog2(L1_WAYS);
  localparam int TLB_WAY_W = $clog2(TLB_WAYS);

  typedef struct packed {
    logic                 valid;
    logic [LINE_W-1:0]    line;
    logic [L1_WAY_W-1:0]  l1_way;
    logic [TLB_WAY_W-1:0] tlb_way;
  } memo_t;
endpackage

// File: rtl/wm_entry.sv
module wm_entry
  import wm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fill_we_i,
  input  logic [LINE_W-1:0]    fill_line_i,
  input  logic [L1_WAY_W-1:0]  fill_l1_way_i,
  input  logic [TLB_WAY_W-1:0] fill_tlb_way_i,
  input  logic                 kill_i,
  input  logic                 l1_inv_i,
  input  logic [SET_W-1:0]     l1_inv_set_i,
  input  logic [L1_WAY_W-1:0]  l1_inv_way_i,
  input  logic                 tlb_inv_i,
  input  logic [TLB_WAY_W-1:0] tlb_inv_way_i,
  output memo_t                entry_o
);
  memo_t entry_q;
  logic  drop_cur, drop_new;

  always_comb begin
    drop_cur = kill_i
             | (l1_inv_i && entry_q.line[SET_W-1:0] == l1_inv_set_i
                         && entry_q.l1_way == l1_inv_way_i)
             | (tlb_inv_i && entry_q.tlb_way == tlb_inv_way_i);
    // a fill that is stale on arrival must not be recorded
    drop_new = kill_i
             | (l1_inv_i && fill_line_i[SET_W-1:0] == l1_inv_set_i
                         && fill_l1_way_i == l1_inv_way_i)
             | (tlb_inv_i && fill_tlb_way_i == tlb_inv_way_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
    end else if (fill_we_i) begin
      entry_q.valid   <= !drop_new;
      entry_q.line    <= fill_line_i;
      entry_q.l1_way  <= fill_l1_way_i;
      entry_q.tlb_way <= fill_tlb_way_i;
    end else if (drop_cur) begin
      entry_q.valid <= 1'b0;
    end
  end

  assign entry_o = entry_q;
endmodule

// File: rtl/wm_match.sv
module wm_match
  import wm_pkg::*;
(
  input  memo_t                 table_i [NUM_REGS],
  input  logic                  valid_i,
  input  logic                  is_load_i,
  input  logic [REG_W-1:0]      base_i,
  input  logic [LINE_W-1:0]     line_i,
  output logic                  hit_o,
  output logic [L1_WAY_W-1:0]   l1_way_o,
  output logic [TLB_WAY_W-1:0]  tlb_way_o,
  output logic                  tag_en_o,
  output logic                  tlb_en_o,
  output logic [L1_WAYS-1:0]    data_way_en_o
);
  memo_t sel;

  always_comb begin
    sel           = table_i[base_i];
    hit_o         = valid_i && sel.valid && (sel.line == line_i);
    l1_way_o      = hit_o ? sel.l1_way  : '0;
    tlb_way_o     = hit_o ? sel.tlb_way : '0;
    tag_en_o      = valid_i && !hit_o;
    tlb_en_o      = valid_i && !hit_o;
    data_way_en_o = '0;
    if (valid_i && is_load_i) begin
      if (hit_o) data_way_en_o[sel.l1_way] = 1'b1;
      else       data_way_en_o = '1;
    end
  end
endmodule

// File: rtl/way_memo_unit.sv
module way_memo_unit
  import wm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lk_valid_i,
  input  logic                 lk_is_load_i,
  input  logic [REG_W-1:0]     lk_base_i,
  input  logic [ADDR_W-1:0]    lk_addr_i,
  output logic                 lk_hit_o,
  output logic [L1_WAY_W-1:0]  lk_l1_way_o,
  output logic [TLB_WAY_W-1:0] lk_tlb_way_o,
  output logic                 tag_en_o,
  output logic                 tlb_en_o,
  output logic [L1_WAYS-1:0]   data_way_en_o,
  input  logic                 fill_valid_i,
  input  logic [REG_W-1:0]     fill_reg_i,
  input  logic [ADDR_W-1:0]    fill_addr_i,
  input  logic [L1_WAY_W-1:0]  fill_l1_way_i,
  input  logic [TLB_WAY_W-1:0] fill_tlb_way_i,
  input  logic                 rwr_valid_i,
  input  logic [REG_W-1:0]     rwr_reg_i,
  input  logic                 l1_inv_valid_i,
  input  logic [SET_W-1:0]     l1_inv_set_i,
  input  logic [L1_WAY_W-1:0]  l1_inv_way_i,
  input  logic                 tlb_inv_valid_i,
  input  logic [TLB_WAY_W-1:0] tlb_inv_way_i
);
  memo_t             memo_tbl [NUM_REGS];
  logic [LINE_W-1:0] fill_line;

  assign fill_line = fill_addr_i[ADDR_W-1:OFF_W];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    wm_entry u_entry (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .fill_we_i      (fill_valid_i && fill_reg_i == REG_W'(r)),
      .fill_line_i    (fill_line),
      .fill_l1_way_i  (fill_l1_way_i),
      .fill_tlb_way_i (fill_tlb_way_i),
      .kill_i         (rwr_valid_i && rwr_reg_i == REG_W'(r)),
      .l1_inv_i       (l1_inv_valid_i),
      .l1_inv_set_i   (l1_inv_set_i),
      .l1_inv_way_i   (l1_inv_way_i),
      .tlb_inv_i      (tlb_inv_valid_i),
      .tlb_inv_way_i  (tlb_inv_way_i),
      .entry_o        (memo_tbl[r])
    );
  end

  wm_match u_match (
    .table_i       (memo_tbl),
    .valid_i       (lk_valid_i),
    .is_load_i     (lk_is_load_i),
    .base_i        (lk_base_i),
    .line_i        (lk_addr_i[ADDR_W-1:OFF_W]),
    .hit_o         (lk_hit_o),
    .l1_way_o      (lk_l1_way_o),
    .tlb_way_o     (lk_tlb_way_o),
    .tag_en_o      (tag_en_o),
    .tlb_en_o      (tlb_en_o),
    .data_way_en_o (data_way_en_o)
  );
endmodule

// File: rtl/wm_checker.sv
module wm_checker
  import wm_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lk_valid_i,
  input logic                 lk_is_load_i,
  input logic [REG_W-1:0]     lk_base_i,
  input logic [ADDR_W-1:0]    lk_addr_i,
  input logic                 lk_hit_o,
  input logic [L1_WAY_W-1:0]  lk_l1_way_o,
  input logic [TLB_WAY_W-1:0] lk_tlb_way_o,
  input logic                 tag_en_o,
  input logic                 tlb_en_o,
  input logic [L1_WAYS-1:0]   data_way_en_o,
  input logic                 rwr_valid_i,
  input logic [REG_W-1:0]     rwr_reg_i,
  input logic                 l1_inv_valid_i,
  input logic [SET_W-1:0]     l1_inv_set_i,
  input logic [L1_WAY_W-1:0]  l1_inv_way_i,
  input logic                 tlb_inv_valid_i,
  input logic [TLB_WAY_W-1:0] tlb_inv_way_i
);
  a_r3_no_hit_without_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_valid_i);

  a_r4_hit_skips_lookups: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (!tag_en_o && !tlb_en_o));

  a_r4_miss_does_lookups: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_hit_o) |-> (tag_en_o && tlb_en_o));

  a_r5_load_hit_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_is_load_i) |->
      ($countones(data_way_en_o) == 1 && data_way_en_o[lk_l1_way_o]));

  a_r5_store_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_is_load_i) |-> data_way_en_o == '0);

  a_r7_regwrite_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwr_valid_i |=> !(lk_hit_o && lk_base_i == $past(rwr_reg_i)));

  a_r8_l1_evict_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_inv_valid_i |=> !(lk_hit_o && lk_l1_way_o == $past(l1_inv_way_i)
                         && lk_addr_i[OFF_W +: SET_W] == $past(l1_inv_set_i)));

  a_r9_tlb_replace_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_inv_valid_i |=> !(lk_hit_o && lk_tlb_way_o == $past(tlb_inv_way_i)));
endmodule

bind way_memo_unit wm_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lk_valid_i      (lk_valid_i),
  .lk_is_load_i    (lk_is_load_i),
  .lk_base_i       (lk_base_i),
  .lk_addr_i       (lk_addr_i),
  .lk_hit_o        (lk_hit_o),
  .lk_l1_way_o     (lk_l1_way_o),
  .lk_tlb_way_o    (lk_tlb_way_o),
  .tag_en_o        (tag_en_o),
  .tlb_en_o        (tlb_en_o),
  .data_way_en_o   (data_way_en_o),
  .rwr_valid_i     (rwr_valid_i),
  .rwr_reg_i       (rwr_reg_i),
  .l1_inv_valid_i  (l1_inv_valid_i),
  .l1_inv_set_i    (l1_inv_set_i),
  .l1_inv_way_i    (l1_inv_way_i),
  .tlb_inv_valid_i (tlb_inv_valid_i),
  .tlb_inv_way_i   (tlb_inv_way_i)
);

// File: tb/sim_way_memo_unit.sv
`timescale 1ns/1ps
module sim_way_memo_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 0, lk_is_load_i = 0;
  logic [4:0]  lk_base_i = 0;
  logic [31:0] lk_addr_i = 0;
  logic        lk_hit_o, tag_en_o, tlb_en_o;
  logic [1:0]  lk_l1_way_o, lk_tlb_way_o;
  logic [3:0]  data_way_en_o;
  logic        fill_valid_i = 0;
  logic [4:0]  fill_reg_i = 0;
  logic [31:0] fill_addr_i = 0;
  logic [1:0]  fill_l1_way_i = 0, fill_tlb_way_i = 0;
  logic        rwr_valid_i = 0;
  logic [4:0]  rwr_reg_i = 0;
  logic        l1_inv_valid_i = 0;
  logic [5:0]  l1_inv_set_i = 0;
  logic [1:0]  l1_inv_way_i = 0;
  logic        tlb_inv_valid_i = 0;
  logic [1:0]  tlb_inv_way_i = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference: one record per register
  bit          m_valid [32];
  logic [25:0] m_line  [32];
  int          m_l1    [32];
  int          m_tlb   [32];

  always #5 clk_i = ~clk_i;

  way_memo_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return 32'((tag << 12) | (set << 6) | off);
  endfunction

  task automatic compare(input string tag);
    bit exp_hit;
    int exp_en;
    exp_hit = lk_valid_i && m_valid[lk_base_i] && m_line[lk_base_i] == lk_addr_i[31:6];
    chk(lk_hit_o == exp_hit, tag, "hit", lk_hit_o, exp_hit);
    chk(tag_en_o == (lk_valid_i && !exp_hit), "R4", "tag_en", tag_en_o, lk_valid_i && !exp_hit);
    chk(tlb_en_o == (lk_valid_i && !exp_hit), "R4", "tlb_en", tlb_en_o, lk_valid_i && !exp_hit);
    exp_en = 0;
    if (lk_valid_i && lk_is_load_i) exp_en = exp_hit ? (1 << m_l1[lk_base_i]) : 'hf;
    chk(data_way_en_o == 4'(exp_en), "R5", "data_way_en", data_way_en_o, exp_en);
    if (exp_hit) begin
      chk(lk_l1_way_o == 2'(m_l1[lk_base_i]), "R2", "l1_way", lk_l1_way_o, m_l1[lk_base_i]);
      chk(lk_tlb_way_o == 2'(m_tlb[lk_base_i]), "R2", "tlb_way", lk_tlb_way_o, m_tlb[lk_base_i]);
    end
  endtask

  task automatic update_model();
    bit kill, stale;
    for (int r = 0; r < 32; r++) begin
      kill = rwr_valid_i && rwr_reg_i == 5'(r);
      if (fill_valid_i && fill_reg_i == 5'(r)) begin
        stale = kill
             || (l1_inv_valid_i && fill_addr_i[11:6] == l1_inv_set_i && fill_l1_way_i == l1_inv_way_i)
             || (tlb_inv_valid_i && fill_tlb_way_i == tlb_inv_way_i);
        m_valid[r] = !stale;
        m_line[r]  = fill_addr_i[31:6];
        m_l1[r]    = fill_l1_way_i;
        m_tlb[r]   = fill_tlb_way_i;
      end else if (kill
             || (l1_inv_valid_i && m_line[r][5:0] == l1_inv_set_i && m_l1[r] == l1_inv_way_i)
             || (tlb_inv_valid_i && m_tlb[r] == tlb_inv_way_i)) begin
        m_valid[r] = 0;
      end
    end
  endtask

  // called at a negedge with inputs set; checks, clocks, clears inputs
  task automatic cyc(input string tag);
    #2 compare(tag);
    @(posedge clk_i);
    update_model();
    @(negedge clk_i);
    lk_valid_i = 0; fill_valid_i = 0; rwr_valid_i = 0;
    l1_inv_valid_i = 0; tlb_inv_valid_i = 0;
  endtask

  task automatic look(input int r, input logic [31:0] a, input bit ld, input string tag);
    lk_valid_i = 1; lk_base_i = 5'(r); lk_addr_i = a; lk_is_load_i = ld;
    cyc(tag);
  endtask

  task automatic fill(input int r, input logic [31:0] a, input int w, input int t);
    fill_valid_i = 1; fill_reg_i = 5'(r); fill_addr_i = a;
    fill_l1_way_i = 2'(w); fill_tlb_way_i = 2'(t);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) begin m_valid[r] = 0; m_line[r] = 0; m_l1[r] = 0; m_tlb[r] = 0; end
    repeat (3) @(negedge clk_i);
    // R1: reset state, every register misses
    for (int r = 0; r < 32; r++) look(r, mk(r, r, 0), 1, "R1");
    rst_ni = 1;
    @(negedge clk_i);
    look(5, mk(1, 2, 0), 1, "R1");
    // R6, R2: fill then hit at any offset in the line
    fill(5, mk(1, 2, 8), 2, 1); cyc("R6");
    look(5, mk(1, 2, 0), 1, "R6");
    look(5, mk(1, 2, 60), 1, "R2");
    look(5, mk(1, 2, 4), 0, "R5");
    // R3: other line, same set other tag, no lookup
    look(5, mk(1, 3, 0), 1, "R3");
    look(5, mk(2, 2, 0), 1, "R3");
    look(4, mk(1, 2, 0), 1, "R3");
    cyc("R3");
    // R11 then R7
    fill(6, mk(3, 9, 0), 1, 0); cyc("R6");
    rwr_valid_i = 1; rwr_reg_i = 5; look(5, mk(1, 2, 16), 1, "R11");
    look(5, mk(1, 2, 16), 1, "R7");
    look(6, mk(3, 9, 0), 1, "R7");
    // R8: eviction of set 4 way 1
    fill(7, mk(1, 4, 0), 1, 0); cyc("R8");
    fill(8, mk(2, 4, 0), 2, 0); cyc("R8");
    fill(9, mk(3, 5, 0), 1, 0); cyc("R8");
    l1_inv_valid_i = 1; l1_inv_set_i = 4; l1_inv_way_i = 1; look(7, mk(1, 4, 0), 1, "R11");
    look(7, mk(1, 4, 0), 1, "R8");
    look(8, mk(2, 4, 0), 1, "R8");
    look(9, mk(3, 5, 0), 1, "R8");
    // R9: TLB way 3 replaced
    fill(10, mk(1, 6, 0), 0, 3); cyc("R9");
    fill(11, mk(1, 7, 0), 0, 0); cyc("R9");
    tlb_inv_valid_i = 1; tlb_inv_way_i = 3; cyc("R9");
    look(10, mk(1, 6, 0), 1, "R9");
    look(11, mk(1, 7, 0), 1, "R9");
    // R10: fills that arrive stale
    fill(12, mk(1, 8, 0), 0, 0); rwr_valid_i = 1; rwr_reg_i = 12; cyc("R10");
    look(12, mk(1, 8, 0), 1, "R10");
    fill(13, mk(1, 8, 0), 0, 2); tlb_inv_valid_i = 1; tlb_inv_way_i = 2; cyc("R10");
    look(13, mk(1, 8, 0), 1, "R10");
    fill(14, mk(1, 10, 0), 3, 0); l1_inv_valid_i = 1; l1_inv_set_i = 10; l1_inv_way_i = 3; cyc("R10");
    look(14, mk(1, 10, 0), 1, "R10");
    // random traffic over a small address space
    for (int i = 0; i < 4000; i++) begin
      lk_valid_i = ($urandom_range(0, 3) != 0);
      lk_is_load_i = 1'($urandom);
      lk_base_i = 5'($urandom_range(0, 7));
      lk_addr_i = mk($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 63));
      if ($urandom_range(0, 2) == 0)
        fill($urandom_range(0, 7), mk($urandom_range(0, 1), $urandom_range(0, 3), 0),
             $urandom_range(0, 3), $urandom_range(0, 3));
      rwr_valid_i = ($urandom_range(0, 9) == 0); rwr_reg_i = 5'($urandom_range(0, 7));
      l1_inv_valid_i = ($urandom_range(0, 9) == 0);
      l1_inv_set_i = 6'($urandom_range(0, 3)); l1_inv_way_i = 2'($urandom);
      tlb_inv_valid_i = ($urandom_range(0, 14) == 0); tlb_inv_way_i = 2'($urandom);
      cyc("R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule